// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable behavioural model of a 4 Kbit serial EEPROM that is reached over a chip-select, serial-clock, data-in and data-out link. An `org` input chooses between two views of the same storage: sixteen-bit words (`org`=1, 256 words) or bytes (`org`=0, 512 bytes). The serial pins are sampled by the system clock. A rising edge on the serial clock moves one bit into the instruction decoder. The decoder recognises read, single-location write and erase, whole-array write and erase, and the two instructions that set and clear a programming lock.

Programming instructions start a self-timed cycle. Its length is set in system clocks by a parameter. During that cycle the host can poll ready/busy on the data output. To do so it drops chip select for a minimum time and raises it again. Reads stream data continuously for as long as chip select stays high. The data output is modelled as a value plus an output enable, so the surrounding code can build the tri-state pad.

Top module: `serial3w_eeprom`

## Requirements
- R1: After reset the output enable is low, programming is locked, and every bit of the array reads as 1.
- R2: With chip select high, leading 0 bits are ignored. An instruction is a 1 start bit, then a 2-bit opcode, then the address, all sent MSB first. The address is 8 bits when `org`=1 and 9 bits when `org`=0. The opcodes are read=10, write=01 and erase=11. Opcode 00 takes the two most significant address bits as a sub-code: 11 unlocks, 10 erases everything, 01 writes everything and 00 locks. The other address bits are don't-care.
- R3: A read drives a single 0 on the output once the last address bit has been taken. Each later serial-clock rise then presents the next data bit, MSB first. The output changes only on serial-clock rises.
- R4: While chip select stays high, a read continues into the next location with no extra 0 bit. The location after the last one is location 0.
- R5: While locked, write, erase, write-all and erase-all change nothing and start no busy cycle.
- R6: The unlock instruction allows programming until a lock instruction arrives. After the lock, programming instructions are ignored again.
- R7: A write stores its 16-bit data (`org`=1) or 8-bit data (`org`=0) at the addressed location. In byte view, byte address 2k+1 is the upper half of word k and 2k is the lower half.
- R8: Erase sets the addressed location to all ones. Erase-all does the same for every location.
- R9: Write-all stores its data pattern in every location. In byte view the pattern fills both halves of each word.
- R10: A programming cycle starts when the last data bit (write, write-all) or the last address bit (erase, erase-all) is taken. The device is busy for PROG_CYCLES system clocks. Any instruction that arrives while busy is ignored.
- R11: If chip select has been low for at least CS_LOW_MIN clocks and rises while busy, the output is enabled and shows 0 while busy and 1 once the cycle is done. If the rise comes after the cycle has finished, the output stays disabled. A low chip select disables the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; bits are taken on its rising edge |
| di | input | 1 | Serial data in |
| org | input | 1 | Organisation: 1 = 16-bit words, 0 = bytes |
| dout | output | 1 | Serial data out value |
| dout_en | output | 1 | Output enable for the data out pad |

## Verification
The bench reads across the wrap point in both organisations. A pointer that saturates, or that wraps at the wrong width, returns the wrong third word. It also checks that the dummy 0 appears exactly once; a design that repeats it shifts every later word by one bit. A second write is sent inside the busy window, and a status poll is made just after the cycle has ended. A design that ignores the busy flag corrupts the second location, and one that keys status on any chip-select rise drives the pin when it must float. Writes in byte view check the half-word mapping and the lock state after reset and after a lock instruction.

// File: rtl/ee3w_pkg.sv
// Shared types for the three-wire serial EEPROM model.
// Holds the opcode field values, the decoded command kinds and the
// decoder states, plus the sub-code decode used by the instruction front end.
package ee3w_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OPC_SPECIAL = 2'b00,
        OPC_WRITE   = 2'b01,
        OPC_READ    = 2'b10,
        OPC_ERASE   = 2'b11
    } opc_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WRITE,
        CMD_ERASE,
        CMD_ERALL,
        CMD_WRALL,
        CMD_UNLOCK,
        CMD_LOCK
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADR,
        ST_DAT,
        ST_RD,
        ST_HOLD
    } st_e;

    // Map the opcode and the two top address bits to a command kind
    function automatic cmd_e decode_cmd(input logic [1:0] opc, input logic [1:0] sub);
        cmd_e k;
        unique case (opc)
            OPC_WRITE: k = CMD_WRITE;
            OPC_ERASE: k = CMD_ERASE;
            OPC_READ:  k = CMD_NONE;
            default: begin
                unique case (sub)
                    2'b11:   k = CMD_UNLOCK;
                    2'b10:   k = CMD_ERALL;
                    2'b01:   k = CMD_WRALL;
                    default: k = CMD_LOCK;
                endcase
            end
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ee3w_link.sv
// Pin front end: finds serial-clock rises while selected, measures how long
// chip select has been low, and owns the ready/busy status window.
// Assumes cs, sk and di are already synchronous to clk and that each sk
// phase lasts at least two clk cycles.
module ee3w_link #(
    parameter int CS_LOW_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic busy,
    input  logic start_seen,
    output logic sk_rise,
    output logic status_on
);
    localparam int CW = $clog2(CS_LOW_MIN + 1);

    logic          sk_q;
    logic          cs_q;
    logic [CW-1:0] low_cnt;
    logic          cs_rise;
    logic          low_ok;

    assign sk_rise = cs & sk & ~sk_q;
    assign cs_rise = cs & ~cs_q;
    assign low_ok  = (low_cnt >= CW'(CS_LOW_MIN));

    // Previous pin values for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sk;
            cs_q <= cs;
        end
    end

    // Saturating count of clocks spent with chip select low
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (cs)
            low_cnt <= '0;
        else if (!low_ok)
            low_cnt <= low_cnt + CW'(1);
    end

    // Status window opens on a qualified select while busy, closes on deselect or new start bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_on <= 1'b0;
        else if (!cs)
            status_on <= 1'b0;
        else if (cs_rise && low_ok && busy)
            status_on <= 1'b1;
        else if (start_seen)
            status_on <= 1'b0;
    end

    // R11
    status_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_on) |-> $past(busy));

    // R11
    status_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_on |-> $past(cs));

endmodule

// File: rtl/ee3w_cmd.sv
// Instruction decoder and read streamer. It shifts in start bit, opcode,
// address and data on serial-clock rises, issues one-cycle commands to the
// store, and serialises read words with a single leading 0.
// Assumes sk phases span at least two clk cycles, so the read word can be
// loaded on a clock between serial-clock rises.
module ee3w_cmd
    import ee3w_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk_rise,
    input  logic              di,
    input  logic              org,
    input  logic              busy,
    input  logic [WORD_W-1:0] rd_word,
    output logic [AW-1:0]     rd_addr,
    output logic              cmd_valid,
    output cmd_e              cmd_kind,
    output logic [AW-1:0]     cmd_addr,
    output logic [WORD_W-1:0] cmd_data,
    output logic              rd_drive,
    output logic              rd_bit,
    output logic              start_seen
);
    localparam int CW = $clog2(WORD_W + 1);

    st_e               st;
    logic [1:0]        opc;
    logic [AW-1:0]     adr_sh;
    logic [WORD_W-1:0] dat_sh;
    logic [CW-1:0]     cnt;
    logic [AW-1:0]     ptr;
    logic [WORD_W-1:0] rd_sh;
    logic [CW-1:0]     rd_left;
    logic              loaded;

    logic [CW-1:0]     alen;
    logic [CW-1:0]     dlen;
    logic [AW-1:0]     adr_next;
    logic [AW-1:0]     adr_in;
    logic [WORD_W-1:0] dat_next;
    logic [1:0]        sub;
    logic [AW-1:0]     ptr_next;
    cmd_e              kind;

    // Field lengths, assembled fields and the next read pointer
    always_comb begin
        alen     = org ? CW'(AW - 1) : CW'(AW);
        dlen     = org ? CW'(WORD_W) : CW'(BYTE_W);
        adr_next = {adr_sh[AW-2:0], di};
        adr_in   = org ? {1'b0, adr_next[AW-2:0]} : adr_next;
        sub      = org ? adr_in[AW-2:AW-3] : adr_in[AW-1:AW-2];
        dat_next = {dat_sh[WORD_W-2:0], di};
        ptr_next = org ? {1'b0, ptr[AW-2:0] + (AW-1)'(1)} : ptr + AW'(1);
        kind     = decode_cmd(opc, sub);
    end

    assign rd_addr = ptr;

    // Serial instruction state machine and read shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            opc        <= '0;
            adr_sh     <= '0;
            dat_sh     <= '0;
            cnt        <= '0;
            ptr        <= '0;
            rd_sh      <= '0;
            rd_left    <= '0;
            loaded     <= 1'b0;
            rd_drive   <= 1'b0;
            rd_bit     <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_kind   <= CMD_NONE;
            cmd_addr   <= '0;
            cmd_data   <= '0;
            start_seen <= 1'b0;
        end else if (!cs) begin
            st         <= ST_IDLE;
            rd_drive   <= 1'b0;
            cmd_valid  <= 1'b0;
            start_seen <= 1'b0;
        end else begin
            cmd_valid  <= 1'b0;
            start_seen <= 1'b0;
            if (sk_rise) begin
                unique case (st)
                    ST_IDLE: begin
                        if (di && !busy) begin
                            st         <= ST_OPC;
                            cnt        <= '0;
                            adr_sh     <= '0;
                            dat_sh     <= '0;
                            start_seen <= 1'b1;
                        end
                    end
                    ST_OPC: begin
                        opc <= {opc[0], di};
                        if (cnt == CW'(1)) begin
                            st  <= ST_ADR;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_ADR: begin
                        adr_sh <= adr_next;
                        if (cnt == alen - CW'(1)) begin
                            cmd_addr <= adr_in;
                            cnt      <= '0;
                            if (opc == OPC_READ) begin
                                st       <= ST_RD;
                                ptr      <= adr_in;
                                rd_left  <= dlen;
                                loaded   <= 1'b0;
                                rd_bit   <= 1'b0;
                                rd_drive <= 1'b1;
                            end else if (kind == CMD_WRITE || kind == CMD_WRALL) begin
                                st       <= ST_DAT;
                                cmd_kind <= kind;
                            end else begin
                                st        <= ST_HOLD;
                                cmd_kind  <= kind;
                                cmd_valid <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_DAT: begin
                        dat_sh <= dat_next;
                        if (cnt == dlen - CW'(1)) begin
                            cmd_data  <= dat_next;
                            cmd_valid <= 1'b1;
                            st        <= ST_HOLD;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_RD: begin
                        rd_bit <= rd_sh[WORD_W-1];
                        rd_sh  <= {rd_sh[WORD_W-2:0], 1'b0};
                        if (rd_left == CW'(1)) begin
                            ptr     <= ptr_next;
                            loaded  <= 1'b0;
                            rd_left <= dlen;
                        end else begin
                            rd_left <= rd_left - CW'(1);
                        end
                    end
                    default: ;
                endcase
            end else if (st == ST_RD && !loaded) begin
                rd_sh  <= rd_word;
                loaded <= 1'b1;
            end
        end
    end

    // R2
    cmd_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(sk_rise));

    // R3
    rd_bit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sk_rise |=> $stable(rd_bit));

    // R3
    rd_cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_drive, cmd_valid}));

endmodule

// File: rtl/ee3w_store.sv
// Storage array, programming lock and self-timed cycle timer.
// Applies a command the cycle it arrives (if allowed) and then holds busy
// for PROG_CYCLES clocks. Commands seen while busy are dropped.
// Assumes org is static while a command is in flight.
module ee3w_store
    import ee3w_pkg::*;
#(
    parameter int WORDS       = 256,
    parameter int AW          = 9,
    parameter int PROG_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              org,
    input  logic              cmd_valid,
    input  cmd_e              cmd_kind,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word,
    output logic              busy,
    output logic              prog_en
);
    localparam int WA = AW - 1;
    localparam int TW = $clog2(PROG_CYCLES + 1);

    logic [WORD_W-1:0] mem [WORDS];
    logic [TW-1:0]     timer;
    logic [WA-1:0]     loc;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] pat;
    logic [WA-1:0]     rloc;
    logic [WORD_W-1:0] rword;
    logic              is_prog;

    // Target word, lane mask and fill pattern for the incoming command
    always_comb begin
        loc  = org ? cmd_addr[WA-1:0] : cmd_addr[AW-1:1];
        mask = org ? '1 : (cmd_addr[0] ? 16'hFF00 : 16'h00FF);
        if (cmd_kind == CMD_ERASE || cmd_kind == CMD_ERALL)
            pat = '1;
        else
            pat = org ? cmd_data : {cmd_data[BYTE_W-1:0], cmd_data[BYTE_W-1:0]};
        is_prog = (cmd_kind == CMD_WRITE) || (cmd_kind == CMD_ERASE) ||
                  (cmd_kind == CMD_ERALL) || (cmd_kind == CMD_WRALL);
    end

    // Read view: whole word, or the selected byte left-aligned
    always_comb begin
        rloc  = org ? rd_addr[WA-1:0] : rd_addr[AW-1:1];
        rword = mem[rloc];
        if (org)
            rd_word = rword;
        else
            rd_word = {(rd_addr[0] ? rword[15:8] : rword[7:0]), 8'h00};
    end

    // Array update, lock latch and busy timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
            busy    <= 1'b0;
            timer   <= '0;
            prog_en <= 1'b0;
        end else begin
            if (busy) begin
                if (timer == '0) busy <= 1'b0;
                else             timer <= timer - TW'(1);
            end
            if (cmd_valid && !busy) begin
                if (cmd_kind == CMD_UNLOCK)
                    prog_en <= 1'b1;
                else if (cmd_kind == CMD_LOCK)
                    prog_en <= 1'b0;
                else if (is_prog && prog_en) begin
                    busy  <= 1'b1;
                    timer <= TW'(PROG_CYCLES - 1);
                    if (cmd_kind == CMD_ERALL || cmd_kind == CMD_WRALL) begin
                        for (int i = 0; i < WORDS; i++) mem[i] <= pat;
                    end else begin
                        mem[loc] <= (mem[loc] & ~mask) | (pat & mask);
                    end
                end
            end
        end
    end

    // R5
    prog_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(prog_en) && $past(cmd_valid));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && timer != '0) |=> busy);

    // R6
    lock_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_en) |-> $past(cmd_valid));

endmodule

// File: rtl/serial3w_eeprom.sv
// Top of the three-wire serial EEPROM model. Joins the pin front end, the
// instruction decoder and the storage, and muxes the data-out pin between
// read data and ready/busy status.
// Assumes MEM_BITS is a power of two of at least 512 bits.
module serial3w_eeprom
    import ee3w_pkg::*;
#(
    parameter int MEM_BITS    = 4096,
    parameter int PROG_CYCLES = 500000,
    parameter int CS_LOW_MIN  = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org,
    output logic dout,
    output logic dout_en
);
    localparam int WORDS = MEM_BITS / WORD_W;
    localparam int AW    = $clog2(WORDS) + 1;

    logic              sk_rise;
    logic              status_on;
    logic              start_seen;
    logic              busy;
    logic              prog_en;
    logic [WORD_W-1:0] rd_word;
    logic [AW-1:0]     rd_addr;
    logic              cmd_valid;
    cmd_e              cmd_kind;
    logic [AW-1:0]     cmd_addr;
    logic [WORD_W-1:0] cmd_data;
    logic              rd_drive;
    logic              rd_bit;

    ee3w_link #(.CS_LOW_MIN(CS_LOW_MIN)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cs),
        .sk         (sk),
        .busy       (busy),
        .start_seen (start_seen),
        .sk_rise    (sk_rise),
        .status_on  (status_on)
    );

    ee3w_cmd #(.AW(AW)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cs),
        .sk_rise    (sk_rise),
        .di         (di),
        .org        (org),
        .busy       (busy),
        .rd_word    (rd_word),
        .rd_addr    (rd_addr),
        .cmd_valid  (cmd_valid),
        .cmd_kind   (cmd_kind),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .rd_drive   (rd_drive),
        .rd_bit     (rd_bit),
        .start_seen (start_seen)
    );

    ee3w_store #(.WORDS(WORDS), .AW(AW), .PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .org        (org),
        .cmd_valid  (cmd_valid),
        .cmd_kind   (cmd_kind),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .rd_addr    (rd_addr),
        .rd_word    (rd_word),
        .busy       (busy),
        .prog_en    (prog_en)
    );

    // Data-out mux: status has priority over read data
    always_comb begin
        dout_en = status_on | rd_drive;
        dout    = status_on ? ~busy : (rd_drive & rd_bit);
    end

    // R11
    float_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cs) |-> !dout_en);

    // R3
    single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status_on, rd_drive}));

endmodule

// File: tb/tb_serial3w_eeprom.sv
module tb_serial3w_eeprom;
    localparam int PROG  = 300;
    localparam int CSMIN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic org = 1'b1;
    logic dout;
    logic dout_en;

    int checks = 0;
    int fails = 0;
    logic [15:0] model [256];
    logic last_o;
    logic last_oe;

    always #5 clk = ~clk;

    serial3w_eeprom #(.MEM_BITS(4096), .PROG_CYCLES(PROG), .CS_LOW_MIN(CSMIN)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        di = b;
        tick(1);
        sk = 1'b1;
        tick(3);
        last_o  = dout;
        last_oe = dout_en;
        sk = 1'b0;
        tick(2);
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    endtask

    task automatic frame_start();
        cs = 1'b0;
        sk = 1'b0;
        tick(CSMIN + 2);
        cs = 1'b1;
        tick(2);
    endtask

    task automatic cmd_head(input logic [1:0] op, input logic [8:0] addr, input int leadz);
        frame_start();
        for (int i = 0; i < leadz; i++) sbit(1'b0);
        sbit(1'b1);
        send_bits({14'd0, op}, 2);
        send_bits({7'd0, addr}, org ? 8 : 9);
    endtask

    task automatic prog_cmd(input logic [1:0] op, input logic [8:0] addr,
                            input logic [15:0] data, input logic has_data, input int leadz);
        cmd_head(op, addr, leadz);
        if (has_data) send_bits(data, org ? 16 : 8);
        cs = 1'b0;
        tick(2);
    endtask

    function automatic logic [8:0] special_addr(input logic [1:0] sub);
        return org ? {1'b0, sub, 6'd0} : {sub, 7'd0};
    endfunction

    function automatic logic [15:0] exp_at(input logic [8:0] a);
        if (org) return model[a[7:0]];
        return a[0] ? {8'h00, model[a[8:1]][15:8]} : {8'h00, model[a[8:1]][7:0]};
    endfunction

    task automatic status_poll();
        cs = 1'b0;
        tick(CSMIN + 2);
        cs = 1'b1;
        tick(3);
        last_o  = dout;
        last_oe = dout_en;
    endtask

    task automatic wait_prog();
        cs = 1'b0;
        tick(PROG + 20);
    endtask

    task automatic rd_check(input string req, input logic [8:0] addr, input int n);
        logic [8:0]  a;
        logic [15:0] w;
        int dl;
        dl = org ? 16 : 8;
        cmd_head(2'b10, addr, 0);
        chk(req, "dummy bit", {31'd0, last_o}, 32'd0);
        chk(req, "dummy enable", {31'd0, last_oe}, 32'd1);
        a = addr;
        for (int k = 0; k < n; k++) begin
            w = '0;
            for (int b = 0; b < dl; b++) begin
                sbit(1'b0);
                w = {w[14:0], last_o};
            end
            chk(req, $sformatf("word at %0d", a), {16'd0, w}, {16'd0, exp_at(a)});
            a = org ? {1'b0, a[7:0] + 8'd1} : a + 9'd1;
        end
        cs = 1'b0;
        tick(2);
    endtask

    task automatic t_reset();
        chk("R1", "dout_en after reset", {31'd0, dout_en}, 32'd0);
        org = 1'b1;
        rd_check("R1", 9'd0, 1);
    endtask

    task automatic t_locked_write();
        prog_cmd(2'b01, 9'd5, 16'h1234, 1'b1, 0);
        status_poll();
        chk("R5", "no busy while locked", {31'd0, last_oe}, 32'd0);
        cs = 1'b0;
        rd_check("R5", 9'd5, 1);
    endtask

    task automatic t_unlock_write_status();
        prog_cmd(2'b00, special_addr(2'b11), 16'h0, 1'b0, 0);
        prog_cmd(2'b01, 9'd5, 16'hA5C3, 1'b1, 0);
        model[5] = 16'hA5C3;
        status_poll();
        chk("R11", "status enable during busy", {31'd0, last_oe}, 32'd1);
        chk("R11", "status busy value", {31'd0, last_o}, 32'd0);
        tick(PROG);
        chk("R11", "status ready value", {31'd0, dout}, 32'd1);
        chk("R11", "status still driven", {31'd0, dout_en}, 32'd1);
        cs = 1'b0;
        tick(2);
        chk("R11", "float when deselected", {31'd0, dout_en}, 32'd0);
        status_poll();
        chk("R11", "no status after cycle end", {31'd0, last_oe}, 32'd0);
        cs = 1'b0;
        rd_check("R7", 9'd5, 1);
    endtask

    task automatic t_busy_ignore();
        // R2: leading zeros before the start bit
        prog_cmd(2'b01, 9'd6, 16'h1111, 1'b1, 3);
        model[6] = 16'h1111;
        prog_cmd(2'b01, 9'd7, 16'h2222, 1'b1, 0);
        wait_prog();
        rd_check("R2", 9'd6, 1);
        rd_check("R10", 9'd7, 1);
    endtask

    task automatic t_byte_view();
        org = 1'b0;
        prog_cmd(2'b01, 9'd9, 16'h005A, 1'b1, 0);
        model[4][15:8] = 8'h5A;
        wait_prog();
        rd_check("R7", 9'd8, 2);
        org = 1'b1;
        rd_check("R7", 9'd4, 1);
    endtask

    task automatic t_wrap();
        org = 1'b1;
        prog_cmd(2'b01, 9'd255, 16'hBEEF, 1'b1, 0);
        model[255] = 16'hBEEF;
        wait_prog();
        prog_cmd(2'b01, 9'd0, 16'h0102, 1'b1, 0);
        model[0] = 16'h0102;
        wait_prog();
        rd_check("R4", 9'd255, 3);
        org = 1'b0;
        rd_check("R4", 9'd510, 3);
        org = 1'b1;
    endtask

    task automatic t_erase();
        org = 1'b1;
        prog_cmd(2'b11, 9'd5, 16'h0, 1'b0, 0);
        model[5] = 16'hFFFF;
        wait_prog();
        rd_check("R8", 9'd4, 2);
    endtask

    task automatic t_all();
        org = 1'b1;
        prog_cmd(2'b00, special_addr(2'b01), 16'h3C3C, 1'b1, 0);
        for (int i = 0; i < 256; i++) model[i] = 16'h3C3C;
        wait_prog();
        rd_check("R9", 9'd0, 1);
        rd_check("R9", 9'd200, 1);
        prog_cmd(2'b00, special_addr(2'b10), 16'h0, 1'b0, 0);
        for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
        wait_prog();
        rd_check("R8", 9'd100, 2);
        org = 1'b0;
        prog_cmd(2'b00, special_addr(2'b01), 16'h0081, 1'b1, 0);
        for (int i = 0; i < 256; i++) model[i] = 16'h8181;
        wait_prog();
        rd_check("R9", 9'd300, 2);
        org = 1'b1;
        rd_check("R9", 9'd77, 1);
    endtask

    task automatic t_lock_again();
        org = 1'b1;
        prog_cmd(2'b00, special_addr(2'b00), 16'h0, 1'b0, 0);
        prog_cmd(2'b01, 9'd3, 16'h0000, 1'b1, 0);
        status_poll();
        chk("R6", "no busy after lock", {31'd0, last_oe}, 32'd0);
        cs = 1'b0;
        rd_check("R6", 9'd3, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        t_reset();
        t_locked_write();
        t_unlock_write_status();
        t_busy_ignore();
        t_byte_view();
        t_wrap();
        t_erase();
        t_all();
        t_lock_again();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule